// File: doc/BRIEF.md
# Lowest-Priority Interrupt Arbitration Unit

This unit decides which of N interrupt-controller agents takes an interrupt that is sent in lowest-priority mode. For every agent it derives an 8-bit arbitration priority from three inputs. The first is the agent's task priority. The second is the highest pending vector in its 256-bit request register. The third is the highest vector in its 256-bit in-service register. Among the agents that the destination mask enables, the one with the smallest arbitration priority is chosen.

A focus indication names one agent. If that agent is in the destination set, it takes the interrupt whatever its priority. A request strobe samples all inputs. One cycle later the unit presents a one-hot winner and a valid flag. Each agent's arbitration priority is also held in a register that can be read as a 32-bit word through a select input.

Top module: `lp_arbiter`

## Requirements
- R1: The pending vector of an agent is the index of the highest set bit of its request register. It is 00h when no request bit is set.
- R2: The in-service vector of an agent is the index of the highest set bit of its in-service register. It is 00h when no in-service bit is set.
- R3: Arbitration priority equals the full task priority when both of these hold: task priority bits [7:4] are greater than or equal to pending vector bits [7:4], and task priority bits [7:4] are strictly greater than in-service vector bits [7:4].
- R4: Otherwise, arbitration priority bits [3:0] are zero. Its bits [7:4] are the larger of pending vector[7:4] and (task priority[7:4] AND in-service vector[7:4]).
- R5: Without a focus override, the winner is the agent in the destination mask with the numerically smallest arbitration priority. On a tie, the lowest agent index wins.
- R6: When focus_en is high and agent focus_sel is in the destination mask, that agent wins regardless of priority. A focus agent outside the mask has no effect.
- R7: A strobe with an empty destination mask gives win_valid low and winner all zeros.
- R8: winner and win_valid are registered. They reflect the inputs sampled on the strobe cycle and appear on the following cycle. In a cycle after a clock edge without a strobe, both are zero.
- R9: rd_data returns the arbitration register of agent rd_sel. Bits [31:8] read as zero and bits [7:0] hold the priority. The register captures the inputs at every clock edge and is zero after reset.
- R10: winner is always one-hot or zero, and win_valid is high exactly when winner is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_strobe | input | 1 | Samples the inputs for one arbitration |
| dest_mask | input | N | Eligible agents, bit i for agent i |
| focus_en | input | 1 | A focus agent is named |
| focus_sel | input | SW | Index of the focus agent |
| task_pri | input | 8*N | Task priority, agent i in bits [8i+7:8i] |
| pend_bits | input | 256*N | Request registers, agent i in bits [256i+255:256i] |
| serv_bits | input | 256*N | In-service registers, agent i in bits [256i+255:256i] |
| rd_sel | input | SW | Agent whose arbitration register is read |
| rd_data | output | 32 | Arbitration register of the selected agent |
| winner | output | N | One-hot accepting agent |
| win_valid | output | 1 | An agent accepted the interrupt |

## Verification
Random agents are generated with zero to three request bits and zero to three in-service bits, together with random task priorities. This drives both branches of the priority blend, and the read-back of every agent's register separates an error in the condition from an error in the nibble merge. Directed cases give several agents equal priorities, which tests the tie rule on index order. They also name a focus agent inside and then outside the mask, which separates a true override from an unconditional one. Strobes with an empty mask and edges without any strobe show whether the outputs really fall to zero.

// File: rtl/lp_arbiter.sv
module lp_arbiter #(
  parameter int N  = 4,
  parameter int PW = 8,
  parameter int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_strobe,
  input  logic [N-1:0]      dest_mask,
  input  logic              focus_en,
  input  logic [SW-1:0]     focus_sel,
  input  logic [N*PW-1:0]   task_pri,
  input  logic [N*(1<<PW)-1:0] pend_bits,
  input  logic [N*(1<<PW)-1:0] serv_bits,
  input  logic [SW-1:0]     rd_sel,
  output logic [31:0]       rd_data,
  output logic [N-1:0]      winner,
  output logic              win_valid
);
  localparam int NVEC = 1 << PW;
  localparam int CW   = 4;
  localparam int LW   = PW - CW;

  function automatic logic [PW-1:0] top_bit(input logic [NVEC-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = 0; i < NVEC; i++)
      if (v[i]) r = PW'(i);
    return r;
  endfunction

  logic [PW-1:0] apr_d [N];
  logic [PW-1:0] apr_q [N];

  for (genvar g = 0; g < N; g++) begin : g_agent
    logic [PW-1:0] tpr, irrv, isrv;
    logic [CW-1:0] blend;
    assign tpr   = task_pri[g*PW +: PW];
    assign irrv  = top_bit(pend_bits[g*NVEC +: NVEC]);
    assign isrv  = top_bit(serv_bits[g*NVEC +: NVEC]);
    assign blend = ((tpr[PW-1 -: CW] & isrv[PW-1 -: CW]) > irrv[PW-1 -: CW])
                 ? (tpr[PW-1 -: CW] & isrv[PW-1 -: CW]) : irrv[PW-1 -: CW];
    assign apr_d[g] = ((tpr[PW-1 -: CW] >= irrv[PW-1 -: CW]) &&
                       (tpr[PW-1 -: CW] >  isrv[PW-1 -: CW]))
                    ? tpr : {blend, {LW{1'b0}}};

    always_ff @(posedge clk)
      if (!rst_n) apr_q[g] <= '0;
      else        apr_q[g] <= apr_d[g];
  end

  logic [N-1:0] pick;
  logic         found;
  logic [PW-1:0] best;
  logic         focus_hit;

  assign focus_hit = focus_en && (int'(focus_sel) < N) && dest_mask[focus_sel];

  always_comb begin
    pick  = '0;
    found = 1'b0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (dest_mask[i] && (!found || apr_d[i] < best)) begin
        found = 1'b1;
        best  = apr_d[i];
        pick  = '0;
        pick[i] = 1'b1;
      end
    end
    if (focus_hit) begin
      pick = '0;
      pick[focus_sel] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !req_strobe) begin
      winner    <= '0;
      win_valid <= 1'b0;
    end else begin
      winner    <= pick;
      win_valid <= |dest_mask;
    end
  end

  assign rd_data = (int'(rd_sel) < N) ? {{(32-PW){1'b0}}, apr_q[rd_sel]} : 32'd0;
endmodule

module lp_arbiter_chk #(
  parameter int N  = 4,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_strobe,
  input logic [N-1:0]  dest_mask,
  input logic          focus_en,
  input logic [SW-1:0] focus_sel,
  input logic [N-1:0]  winner,
  input logic          win_valid
);
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winner));
  a_r10_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid == (winner != '0));
  a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !req_strobe |=> (!win_valid && winner == '0));
  a_r7_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (req_strobe && dest_mask == '0) |=> (!win_valid && winner == '0));
  a_r5_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (req_strobe && dest_mask != '0) |=> (win_valid && (winner & $past(dest_mask)) == winner));
  a_r6_focus: assert property (@(posedge clk) disable iff (!rst_n)
    (req_strobe && focus_en && int'(focus_sel) < N && dest_mask[focus_sel])
      |=> winner[$past(focus_sel)]);
endmodule

bind lp_arbiter lp_arbiter_chk #(.N(N), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_strobe(req_strobe), .dest_mask(dest_mask),
  .focus_en(focus_en), .focus_sel(focus_sel), .winner(winner), .win_valid(win_valid)
);

// File: tb/test_lp_arbiter.sv
module test_lp_arbiter;
  localparam int N = 4;
  localparam int SW = 2;

  logic clk = 0, rst_n = 0, req_strobe = 0, focus_en = 0;
  logic [N-1:0] dest_mask = '0;
  logic [SW-1:0] focus_sel = '0, rd_sel = '0;
  logic [N*8-1:0] task_pri;
  logic [N*256-1:0] pend_bits, serv_bits;
  logic [31:0] rd_data;
  logic [N-1:0] winner;
  logic win_valid;

  logic [7:0]   tp [N];
  logic [255:0] pb [N];
  logic [255:0] sb [N];

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) begin
      task_pri[i*8 +: 8]    = tp[i];
      pend_bits[i*256 +: 256] = pb[i];
      serv_bits[i*256 +: 256] = sb[i];
    end

  lp_arbiter #(.N(N)) i_lp_arbiter (
    .clk(clk), .rst_n(rst_n), .req_strobe(req_strobe), .dest_mask(dest_mask),
    .focus_en(focus_en), .focus_sel(focus_sel), .task_pri(task_pri),
    .pend_bits(pend_bits), .serv_bits(serv_bits), .rd_sel(rd_sel),
    .rd_data(rd_data), .winner(winner), .win_valid(win_valid)
  );

  function automatic logic [7:0] hi_vec(input logic [255:0] v);
    logic [7:0] r = 8'h00;
    for (int i = 255; i >= 0; i--)
      if (v[i]) begin r = 8'(i); break; end
    return r;
  endfunction

  function automatic logic [7:0] ref_apr(input logic [7:0] t, input logic [255:0] p, input logic [255:0] s);
    logic [3:0] tc, pc, sc, a;
    tc = t[7:4]; pc = hi_vec(p) >> 4; sc = hi_vec(s) >> 4;
    if (tc >= pc && tc > sc) return t;
    a = tc & sc;
    return {(a > pc) ? a : pc, 4'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic arbitrate(input logic [N-1:0] m, input bit fe, input int fs, input string req);
    logic [N-1:0] ew = '0;
    logic [7:0] best = 8'hff;
    bit found = 0;
    for (int i = 0; i < N; i++)
      if (m[i] && (!found || ref_apr(tp[i], pb[i], sb[i]) < best)) begin
        found = 1; best = ref_apr(tp[i], pb[i], sb[i]); ew = '0; ew[i] = 1'b1;
      end
    if (fe && m[fs]) begin ew = '0; ew[fs] = 1'b1; end
    dest_mask = m; focus_en = fe; focus_sel = SW'(fs); req_strobe = 1;
    @(negedge clk);
    req_strobe = 0;
    chk(winner == ew, req, 32'(winner), 32'(ew));
    chk(win_valid == (m != '0), "R10 valid", 32'(win_valid), 32'(m != '0));
    for (int i = 0; i < N; i++) begin
      rd_sel = SW'(i); #1;
      chk(rd_data == {24'h0, ref_apr(tp[i], pb[i], sb[i])}, "R9 read", rd_data,
          {24'h0, ref_apr(tp[i], pb[i], sb[i])});
    end
  endtask

  task automatic rand_agent(input int i);
    tp[i] = 8'($urandom);
    pb[i] = '0; sb[i] = '0;
    for (int k = $urandom_range(0, 3); k > 0; k--) pb[i][$urandom_range(0, 255)] = 1'b1;
    for (int k = $urandom_range(0, 3); k > 0; k--) sb[i][$urandom_range(0, 255)] = 1'b1;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin tp[i] = '0; pb[i] = '0; sb[i] = '0; end
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      rd_sel = SW'(i); #1;
      chk(rd_data == 32'd0, "R9 reset", rd_data, 32'd0);
    end
    chk(win_valid == 0 && winner == '0, "R8 reset", 32'(winner), 32'd0);
    rst_n = 1;

    // R1/R3: empty pending, task above in-service -> full task priority
    tp[0] = 8'h57; sb[0][8'h31] = 1'b1;
    // R2/R4: empty in-service, pending class above task class
    tp[1] = 8'h2c; pb[1][8'h6a] = 1'b1;
    // R4: in-service blocks, AND term dominates
    tp[2] = 8'hb3; sb[2][8'hd0] = 1'b1; pb[2][8'h12] = 1'b1;
    tp[3] = 8'h90; pb[3][8'hff] = 1'b1; pb[3][8'h05] = 1'b1;
    arbitrate(4'b1111, 0, 0, "R1 R2 R3 R4 R5 mixed");

    // R5 tie: equal priorities, lowest index in mask wins
    for (int i = 0; i < N; i++) begin tp[i] = 8'h40; pb[i] = '0; sb[i] = '0; end
    arbitrate(4'b1110, 0, 0, "R5 tie");
    arbitrate(4'b1111, 0, 0, "R5 tie all");

    // R6 focus inside and outside mask
    tp[0] = 8'h10; tp[3] = 8'hf0;
    arbitrate(4'b1001, 1, 3, "R6 focus in mask");
    arbitrate(4'b0011, 1, 3, "R6 focus outside mask");

    // R7 empty mask
    arbitrate(4'b0000, 0, 0, "R7 empty");
    arbitrate(4'b0000, 1, 2, "R7 empty focus");

    // R8 no strobe: outputs drop after one cycle
    arbitrate(4'b0100, 0, 0, "R8 single");
    @(negedge clk);
    chk(win_valid == 0 && winner == '0, "R8 no strobe", 32'(winner), 32'd0);

    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < N; i++) rand_agent(i);
      arbitrate(4'($urandom), ($urandom_range(0, 3) == 0), $urandom_range(0, N-1), "R5 R6 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule